// File: doc/BRIEF.md
# Peak-Current PWM Cycle Controller

This block produces the gate-drive pulse of a peak-current-mode switching converter, one pulse per switching period. A period counter, running on the 50 MHz system clock, marks the start of each cycle. At that point the gate is turned on, unless the low-feedback flag shows that the load is almost zero. The pulse ends in one of three ways: a digitised current-sense trip after the blanking window has closed, the maximum-duty point of the period, or the supervisor taking away the run permission.

The pulse cannot be shorter than a blanking window. Inside that window the set request overrides any current trip, so the turn-on surge cannot cut the pulse short. The window is long in steady operation (1250 ns, 63 clocks) and short while the supply is starting or restarting (280 ns, 14 clocks). The period length comes from outside as a clock count, so an outer loop can stretch the period at light load from 60 kHz (833 clocks) down to a few hundred hertz. The block samples that count only when a new cycle begins. Each cycle start is announced by a one-clock strobe so that other logic can count switching cycles.

Top module: `pwm_cycle_ctrl`

## Requirements
- R1: After reset, and while `enable` is low, `gateOut` and `cycleStart` are both 0.
- R2: While `enable` is high, `cycleStart` is a one-clock strobe repeating every P clocks, where P is the effective period. The first strobe appears one clock after the first edge at which `enable` is sampled high.
- R3: `periodCycles` is sampled only at a cycle start. A change in mid-cycle leaves the current cycle's length alone and sets the length of the next cycle.
- R4: A `periodCycles` value below PERIOD_MIN (default 100) is treated as PERIOD_MIN.
- R5: When `fbLow` is 0 at a cycle start, `gateOut` goes high in the same clock as `cycleStart`.
- R6: With no current trip, the gate stays high for floor(P*4/5) clocks (80 % maximum duty). It is then forced low until the next cycle start.
- R7: After blanking, a `currentTrip` sampled high while the gate is on drives the gate low on the next clock. A trip sampled with the cycle at phase j therefore gives an on-time of j+1 clocks.
- R8: With `startupMode` 0 at the cycle start, the gate stays high for at least 63 clocks whatever `currentTrip` does. A trip pulse that ends inside that window is dropped and does not end the pulse later.
- R9: With `startupMode` 1 at the cycle start, the blanking window is 14 clocks, so a trip held from early in the cycle gives a 14-clock pulse.
- R10: When `fbLow` is 1 at a cycle start, the gate stays low for that whole cycle, but `cycleStart` still fires.
- R11: `fbLow` rising after a pulse has begun does not end that pulse.
- R12: `enable` sampled low drives the gate low and stops the cycle strobes on the next clock. When `enable` returns, a fresh cycle starts one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 50 MHz |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run permission from the supervisor; low holds the gate off |
| startupMode | input | 1 | 1 selects the short blanking window for the next cycle |
| fbLow | input | 1 | Digitised flag that the feedback level is near zero; blocks the turn-on at a cycle start |
| currentTrip | input | 1 | Digitised peak-current comparator output |
| periodCycles | input | PERIOD_W | Requested switching period in clocks |
| gateOut | output | 1 | Gate-drive command |
| cycleStart | output | 1 | One-clock strobe at the first clock of every cycle |

## Verification
The bench goes after the edges of the blanking window. A held trip has to end the pulse exactly at clock 63 (or 14 in startup mode). A short trip pulse inside the window has to be forgotten. A design that latched the trip would end that pulse just after blanking, and one with an off-by-one counter would give 62 or 64 clocks. It changes the period in mid-cycle, so a design that loads the count at once shows a wrong length for the current cycle. It also drives values below the floor and long light-load periods, which show up as wrong cycle lengths or duty counts. The flag tests check two things: a low-feedback flag at a cycle start must give a cycle with no pulse and a strobe that still fires, and the same flag raised mid-pulse must not shorten the pulse. The enable tests check that dropping `enable` turns the gate off within one clock and that switching restarts cleanly.

// File: rtl/pwm_cyc_pkg.sv
package pwm_cyc_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic clear;       // hold counters idle
    logic load;        // begin a new cycle, sample period
    logic blankArm;    // start the blanking window
    logic blankShort;  // pick the startup blanking length
  } dpCtl_t;

  // Status from the datapath back to the control
  typedef struct packed {
    logic lastPhase;   // counter sits on the final clock of the period
    logic onEnd;       // next edge reaches the maximum-duty point
    logic blankBusy;   // blanking window still running
  } dpStat_t;

endpackage

// File: rtl/pwm_cyc_datapath.sv
module pwm_cyc_datapath
  import pwm_cyc_pkg::*;
#(
  parameter int PERIOD_W    = 18,
  parameter int PERIOD_MIN  = 100,
  parameter int BLANK_LONG  = 63,
  parameter int BLANK_SHORT = 14,
  parameter int DUTY_NUM    = 4,
  parameter int DUTY_DEN    = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtl_t              ctl,
  input  logic [PERIOD_W-1:0] periodIn,
  output dpStat_t             stat
);

  localparam int BLANK_W   = $clog2(BLANK_LONG + 1);
  localparam int PROD_W    = PERIOD_W + $clog2(DUTY_NUM + 1);
  localparam int DEN_SHIFT = $clog2(DUTY_DEN);
  localparam bit DEN_POW2  = (DUTY_DEN == (1 << DEN_SHIFT));
  localparam logic [PERIOD_W-1:0] MIN_P     = PERIOD_W'(PERIOD_MIN);
  localparam logic [PERIOD_W-1:0] MIN_MAXON = PERIOD_W'((PERIOD_MIN * DUTY_NUM) / DUTY_DEN);
  localparam logic [BLANK_W-1:0]  LONG_LD   = BLANK_W'(BLANK_LONG - 1);
  localparam logic [BLANK_W-1:0]  SHORT_LD  = BLANK_W'(BLANK_SHORT - 1);

  logic [PERIOD_W-1:0] phase;
  logic [PERIOD_W-1:0] periodReg;
  logic [PERIOD_W-1:0] maxOnReg;
  logic [BLANK_W-1:0]  blankRem;

  logic [PERIOD_W-1:0] periodEff;
  logic [PROD_W-1:0]   dutyProd;
  logic [PERIOD_W-1:0] maxOnNext;

  // Clamp a too-short request to the floor
  always_comb begin
    periodEff = (periodIn < MIN_P) ? MIN_P : periodIn;
    dutyProd  = PROD_W'(periodEff) * PROD_W'(DUTY_NUM);
  end

  // Maximum-duty point: shift for a power-of-two denominator, divide otherwise
  generate
    if (DEN_POW2) begin : g_dutyShift
      assign maxOnNext = PERIOD_W'(dutyProd >> DEN_SHIFT);
    end else begin : g_dutyDiv
      assign maxOnNext = PERIOD_W'(dutyProd / PROD_W'(DUTY_DEN));
    end
  endgenerate

  // Period counter and per-cycle registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= '0;
      periodReg <= MIN_P;
      maxOnReg  <= MIN_MAXON;
    end else if (ctl.clear) begin
      phase     <= '0;
    end else if (ctl.load) begin
      phase     <= '0;
      periodReg <= periodEff;
      maxOnReg  <= maxOnNext;
    end else begin
      phase     <= phase + 1'b1;
    end
  end

  // Blanking window counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      blankRem <= '0;
    end else if (ctl.clear) begin
      blankRem <= '0;
    end else if (ctl.blankArm) begin
      blankRem <= ctl.blankShort ? SHORT_LD : LONG_LD;
    end else if (blankRem != '0) begin
      blankRem <= blankRem - 1'b1;
    end
  end

  always_comb begin
    stat.lastPhase = (phase == periodReg - 1'b1);
    stat.onEnd     = (phase + 1'b1 == maxOnReg);
    stat.blankBusy = (blankRem != '0);
  end

  AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    phase < periodReg) else $error("phase beyond period"); // R2

  AST_PERIOD_ONLY_AT_START: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(periodReg) |-> $past(ctl.load)) else $error("period changed mid-cycle"); // R3

  AST_PERIOD_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    periodReg >= MIN_P) else $error("period below floor"); // R4

  AST_DUTY_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    (maxOnReg < periodReg) && (maxOnReg != '0)) else $error("duty point out of range"); // R6

  AST_BLANK_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    blankRem <= LONG_LD) else $error("blanking count too large"); // R9

endmodule

// File: rtl/pwm_cyc_control.sv
module pwm_cyc_control
  import pwm_cyc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    startupMode,
  input  logic    fbLow,
  input  logic    currentTrip,
  input  dpStat_t stat,
  output dpCtl_t  ctl,
  output logic    gate,
  output logic    cycleStart
);

  logic runningQ;
  logic gateQ;
  logic startQ;
  logic boundary;
  logic doSet;
  logic gateNext;

  always_comb begin
    boundary = enable && (!runningQ || stat.lastPhase);
    doSet    = boundary && !fbLow;

    ctl.clear      = !enable;
    ctl.load       = boundary;
    ctl.blankArm   = doSet;
    ctl.blankShort = startupMode;

    // Priority: disable, set, duty limit, current trip after blanking
    if (!enable)                                 gateNext = 1'b0;
    else if (doSet)                              gateNext = 1'b1;
    else if (gateQ && stat.onEnd)                gateNext = 1'b0;
    else if (gateQ && !stat.blankBusy && currentTrip) gateNext = 1'b0;
    else                                         gateNext = gateQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runningQ <= 1'b0;
      gateQ    <= 1'b0;
      startQ   <= 1'b0;
    end else begin
      runningQ <= enable;
      gateQ    <= gateNext;
      startQ   <= boundary;
    end
  end

  assign gate       = gateQ;
  assign cycleStart = startQ;

  AST_DISABLED_GATE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!gateQ && !startQ)) else $error("gate on while disabled"); // R12

  AST_STROBE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    startQ |=> !startQ) else $error("strobe longer than one clock"); // R2

  AST_RISE_AT_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateQ) |-> startQ) else $error("gate rose outside a cycle start"); // R5

  AST_SET_NEEDS_FB: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateQ) |-> !$past(fbLow)) else $error("gate set with feedback low"); // R10

  AST_BLANK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (gateQ && stat.blankBusy && enable && !stat.onEnd) |=> gateQ) else $error("pulse cut inside blanking"); // R8

endmodule

// File: rtl/pwm_cycle_ctrl.sv
module pwm_cycle_ctrl #(
  parameter int PERIOD_W    = 18,
  parameter int PERIOD_MIN  = 100,
  parameter int BLANK_LONG  = 63,
  parameter int BLANK_SHORT = 14,
  parameter int DUTY_NUM    = 4,
  parameter int DUTY_DEN    = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic                startupMode,
  input  logic                fbLow,
  input  logic                currentTrip,
  input  logic [PERIOD_W-1:0] periodCycles,
  output logic                gateOut,
  output logic                cycleStart
);

  pwm_cyc_pkg::dpCtl_t  ctlBus;
  pwm_cyc_pkg::dpStat_t statBus;

  pwm_cyc_control u_control (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .startupMode (startupMode),
    .fbLow       (fbLow),
    .currentTrip (currentTrip),
    .stat        (statBus),
    .ctl         (ctlBus),
    .gate        (gateOut),
    .cycleStart  (cycleStart)
  );

  pwm_cyc_datapath #(
    .PERIOD_W    (PERIOD_W),
    .PERIOD_MIN  (PERIOD_MIN),
    .BLANK_LONG  (BLANK_LONG),
    .BLANK_SHORT (BLANK_SHORT),
    .DUTY_NUM    (DUTY_NUM),
    .DUTY_DEN    (DUTY_DEN)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctlBus),
    .periodIn (periodCycles),
    .stat     (statBus)
  );

endmodule

// File: tb/pwm_cycle_ctrl_bench.sv
module pwm_cycle_ctrl_bench;

  localparam int PW = 18;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          enable = 1'b0;
  logic          startupMode = 1'b0;
  logic          fbLow = 1'b0;
  logic          currentTrip = 1'b0;
  logic [PW-1:0] periodCycles = PW'(833);
  logic          gateOut;
  logic          cycleStart;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  typedef struct {
    int    len;
    int    on;
    string req;
  } expItem_t;

  expItem_t expQ[$];

  always #10 clk = ~clk;

  pwm_cycle_ctrl u_pwm_cycle_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .startupMode  (startupMode),
    .fbLow        (fbLow),
    .currentTrip  (currentTrip),
    .periodCycles (periodCycles),
    .gateOut      (gateOut),
    .cycleStart   (cycleStart)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: measures each finished cycle and compares with the queue
  bit openCyc = 1'b0;
  int mLen = 0;
  int mOn = 0;
  always @(negedge clk) begin
    if (!enable) begin
      openCyc = 1'b0;
    end else if (cycleStart) begin
      if (openCyc) begin
        if (expQ.size() == 0) begin
          check(1'b0, "scoreboard-empty", mLen, 0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(mLen == e.len, {e.req, " cycle length"}, mLen, e.len);
          check(mOn == e.on, {e.req, " on-time"}, mOn, e.on);
        end
      end
      openCyc = 1'b1;
      mLen = 1;
      mOn = gateOut ? 1 : 0;
    end else if (openCyc) begin
      mLen++;
      mOn += gateOut ? 1 : 0;
    end
  end

  // Driver: one call per cycle; windows are in phase units of this cycle
  task automatic runCycle(input bit skipWait, input int expLen, input int expOn,
                          input int tripLo, input int tripHi,
                          input int fbLo, input int fbHi,
                          input bit fbNext, input bit stNext,
                          input int newPeriod, input int newAt, input string req);
    expItem_t e;
    if (!skipWait) begin
      do @(negedge clk); while (!cycleStart);
    end
    e.len = expLen; e.on = expOn; e.req = req;
    expQ.push_back(e);
    for (int j = 0; j < expLen; j++) begin
      if (j > 0) @(negedge clk);
      currentTrip = (j >= tripLo) && (j < tripHi);
      fbLow = (j >= fbLo) && (j < fbHi);
      if (newPeriod > 0 && j == newAt) periodCycles = PW'(newPeriod);
      if (j == expLen - 1) begin
        fbLow = fbNext;
        startupMode = stNext;
      end
    end
  endtask

  task automatic waitStart();
    do @(negedge clk); while (!cycleStart);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: idle after reset and while disabled
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!gateOut, "R1 gate idle", gateOut, 0);
      check(!cycleStart, "R1 strobe idle", cycleStart, 0);
    end
    enable = 1'b1;
    @(negedge clk);
    check(cycleStart, "R2 first strobe latency", cycleStart, 1);
    check(gateOut, "R5 gate with strobe", gateOut, 1);

    runCycle(1, 833, 666, 0, 0, 0, 0, 0, 0, 0, 0, "R6 max duty");
    runCycle(0, 833, 100, 99, 100, 0, 0, 0, 0, 0, 0, "R7 trip end");
    runCycle(0, 833, 63, 4, 70, 0, 0, 0, 0, 0, 0, "R8 held trip in blanking");
    runCycle(0, 833, 666, 20, 21, 0, 0, 0, 1, 0, 0, "R8 trip pulse dropped");
    runCycle(0, 833, 14, 2, 40, 0, 0, 0, 0, 0, 0, "R9 startup blanking");
    runCycle(0, 833, 666, 0, 0, 10, 200, 1, 0, 0, 0, "R11 fbLow mid-pulse");
    runCycle(0, 833, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 suppressed cycle");
    runCycle(0, 833, 666, 0, 0, 0, 0, 0, 0, 1000, 50, "R3 change mid-cycle");
    runCycle(0, 1000, 800, 0, 0, 0, 0, 0, 0, 10, 50, "R3 new period");
    runCycle(0, 100, 80, 0, 0, 0, 0, 0, 0, 5000, 50, "R4 period floor");
    runCycle(0, 5000, 4000, 0, 0, 0, 0, 0, 0, 0, 0, "R2 long period");
    runCycle(0, 5000, 3000, 2999, 3000, 0, 0, 0, 0, 0, 0, "R7 late trip");
    waitStart();

    // R12: drop enable mid-pulse
    repeat (30) @(negedge clk);
    check(gateOut, "R12 gate on before drop", gateOut, 1);
    enable = 1'b0;
    @(negedge clk);
    check(!gateOut, "R12 gate off after drop", gateOut, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(!gateOut && !cycleStart, "R12 idle while disabled", {gateOut, cycleStart}, 0);
    end
    enable = 1'b1;
    @(negedge clk);
    check(cycleStart && gateOut, "R12 restart", {cycleStart, gateOut}, 3);
    runCycle(1, 5000, 4000, 0, 0, 0, 0, 0, 0, 0, 0, "R12 cycle after restart");
    waitStart();
    @(negedge clk);
    check(expQ.size() == 0, "R2 scoreboard drained", expQ.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule